// File: doc/BRIEF.md
# Frame Alignment Measurement Unit

This unit measures how far an external evaluation signal lags the local frame pulse, so that per-stream input offsets can be chosen by the host. It counts in half master-clock periods. The unit's clock `clk` runs at twice the master-clock rate, so one `clk` cycle is one half period. All inputs are sampled on the rising edge of `clk`. An edge is detected when a sample differs from the sample one cycle earlier. No edge is reported on the first sample after reset.

The host arms the unit by holding the start bit low for at least one frame, then raises it. The unit lets the rest of the current frame and the whole next frame pass. It then measures over the frame that follows, which is bounded by the second and third reference edges after the start. It reports a 12-bit offset and a completion flag in one output word. The detected line format decides which edges count. In ST-BUS format, falling edges of both the frame pulse and the evaluation input are used. In GCI format, rising edges are used. The host clears the flag by writing the start bit low. The offset is kept until the next measurement completes.

Top module: `frame_align_meas`

## Requirements
- R1: After reset `align_o` reads all zeros.
- R2: A rise of `start_i` starts a measurement only if `start_i` was sampled low on at least `FRAME_LEN` consecutive cycles just before it. An earlier rise is ignored: the flag never sets for it and the offset field keeps its value.
- R3: The measuring window opens at the second reference edge after the accepted start rise and closes at the third. Evaluation edges sampled before the opening edge are ignored.
- R4: The offset is the number of cycles from the opening reference edge sample to the first qualifying evaluation edge sample in the window. An evaluation edge in the same sample as the opening edge gives 0. Later edges in the window are ignored.
- R5: With `fmt_gci_i`=0 the reference edge is a falling edge of `fp_i` and the qualifying evaluation edge is a falling edge of `ev_i`. With `fmt_gci_i`=1 both are rising edges.
- R6: If no qualifying evaluation edge falls inside the window, the offset becomes all ones (4095 at `OFF_W`=12) and the flag is still set. An edge in the same sample as the closing reference edge is outside the window.
- R7: The completion flag `align_o[OFF_W]` and the offset field `align_o[OFF_W-1:0]` update together, one cycle after the closing reference edge is sampled. The flag is 0 before then.
- R8: The flag clears one cycle after `start_i` is sampled low. The offset field holds its value until the next measurement completes.
- R9: If `start_i` is sampled low before the window closes, the measurement is abandoned. The flag does not set and the offset field is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, twice the master-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| fp_i | input | 1 | Device frame pulse |
| ev_i | input | 1 | Frame evaluation input |
| fmt_gci_i | input | 1 | Detected format: 0 ST-BUS, 1 GCI |
| start_i | input | 1 | Start bit from the control register |
| align_o | output | OFF_W+1 | Bit OFF_W completion flag, bits OFF_W-1:0 offset |

## Verification
An evaluation edge can land in the same sample as a reference edge. This can happen at the edge that opens the window or at the edge that closes it. The bench places an evaluation pulse exactly on each of these edges. A coincidence at the opening edge must read offset 0. A coincidence at the closing edge must read the all-ones value with the flag set. Further directed runs cover the other corners: inverted pulse polarity, an edge in the skipped frame, an early start and an abandoned measurement. Random offsets in both formats complete the coverage, and a bench function gives the expected word for every run.

// File: rtl/fam_pkg.sv
package fam_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SYNC,
    ST_SKIP,
    ST_MEAS
  } fam_state_e;
endpackage

// File: rtl/fam_edge_det.sv
module fam_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  input  logic rise_sel_i,
  output logic edge_o
);
  logic prev_q;
  logic seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      prev_q <= sig_i;
      seen_q <= 1'b1;
    end
  end

  assign edge_o = seen_q & (rise_sel_i ? (sig_i & ~prev_q) : (~sig_i & prev_q));
endmodule

// File: rtl/fam_arm.sv
module fam_arm #(
  parameter int FRAME_LEN = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic fire_o
);
  localparam int CW = $clog2(FRAME_LEN + 1);
  localparam logic [CW-1:0] LOW_MAX = CW'(FRAME_LEN);

  logic          start_q;
  logic [CW-1:0] low_cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q   <= 1'b0;
      low_cnt_q <= '0;
    end else begin
      start_q <= start_i;
      if (start_i)
        low_cnt_q <= '0;
      else if (low_cnt_q != LOW_MAX)
        low_cnt_q <= low_cnt_q + CW'(1);
    end
  end

  assign fire_o = start_i & ~start_q & (low_cnt_q == LOW_MAX);
endmodule

// File: rtl/fam_seq.sv
module fam_seq
  import fam_pkg::*;
#(
  parameter int OFF_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire_i,
  input  logic             start_i,
  input  logic             ref_edge_i,
  input  logic             ev_edge_i,
  output logic [OFF_W-1:0] offset_o,
  output logic             done_o
);
  localparam logic [OFF_W-1:0] SAT = '1;

  fam_state_e       state_q;
  logic [OFF_W-1:0] cnt_q;
  logic [OFF_W-1:0] cap_q;
  logic             got_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      cap_q    <= '0;
      got_q    <= 1'b0;
      offset_o <= '0;
      done_o   <= 1'b0;
    end else begin
      if (!start_i) done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (fire_i) state_q <= ST_SYNC;
        ST_SYNC: begin
          if (!start_i)       state_q <= ST_IDLE;
          else if (ref_edge_i) state_q <= ST_SKIP;
        end
        ST_SKIP: begin
          if (!start_i) state_q <= ST_IDLE;
          else if (ref_edge_i) begin
            state_q <= ST_MEAS;
            cnt_q   <= OFF_W'(1);
            cap_q   <= '0;
            got_q   <= ev_edge_i;
          end
        end
        ST_MEAS: begin
          if (!start_i) state_q <= ST_IDLE;
          else if (ref_edge_i) begin
            offset_o <= got_q ? cap_q : SAT;
            done_o   <= 1'b1;
            state_q  <= ST_IDLE;
          end else begin
            if (ev_edge_i && !got_q) begin
              cap_q <= cnt_q;
              got_q <= 1'b1;
            end
            if (cnt_q != SAT) cnt_q <= cnt_q + OFF_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frame_align_meas.sv
module frame_align_meas #(
  parameter int FRAME_LEN = 1024,
  parameter int OFF_W     = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fp_i,
  input  logic           ev_i,
  input  logic           fmt_gci_i,
  input  logic           start_i,
  output logic [OFF_W:0] align_o
);
  logic             ref_edge;
  logic             ev_edge;
  logic             fire;
  logic [OFF_W-1:0] offset;
  logic             done;

  fam_edge_det u_ref_edge (
    .clk(clk), .rst(rst), .sig_i(fp_i), .rise_sel_i(fmt_gci_i), .edge_o(ref_edge)
  );

  fam_edge_det u_ev_edge (
    .clk(clk), .rst(rst), .sig_i(ev_i), .rise_sel_i(fmt_gci_i), .edge_o(ev_edge)
  );

  fam_arm #(.FRAME_LEN(FRAME_LEN)) u_arm (
    .clk(clk), .rst(rst), .start_i(start_i), .fire_o(fire)
  );

  fam_seq #(.OFF_W(OFF_W)) u_seq (
    .clk(clk), .rst(rst), .fire_i(fire), .start_i(start_i),
    .ref_edge_i(ref_edge), .ev_edge_i(ev_edge),
    .offset_o(offset), .done_o(done)
  );

  assign align_o = {done, offset};
endmodule

// File: rtl/fam_chk.sv
module fam_chk #(
  parameter int FRAME_LEN = 1024,
  parameter int OFF_W     = 12
) (
  input logic           clk,
  input logic           rst,
  input logic           fp_i,
  input logic           fmt_gci_i,
  input logic           start_i,
  input logic [OFF_W:0] align_o
);
  localparam int CW = $clog2(FRAME_LEN + 1);

  logic          fp_q, seen_q, st_q, armed_rise_q;
  logic [CW-1:0] lowc_q;
  logic          ref_c, done_c;
  logic [OFF_W-1:0] off_c;

  assign ref_c  = seen_q & (fmt_gci_i ? (fp_i & ~fp_q) : (~fp_i & fp_q));
  assign done_c = align_o[OFF_W];
  assign off_c  = align_o[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      fp_q <= 1'b0; seen_q <= 1'b0; st_q <= 1'b0;
      lowc_q <= '0; armed_rise_q <= 1'b0;
    end else begin
      fp_q   <= fp_i;
      seen_q <= 1'b1;
      st_q   <= start_i;
      if (start_i) lowc_q <= '0;
      else if (lowc_q != CW'(FRAME_LEN)) lowc_q <= lowc_q + CW'(1);
      if (!start_i) armed_rise_q <= 1'b0;
      else if (!st_q) armed_rise_q <= (lowc_q == CW'(FRAME_LEN));
    end
  end

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> !done_c);

  // R7
  flag_at_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_c) |-> $past(ref_c));

  // R8
  offset_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$rose(done_c) |-> $stable(off_c));

  // R2
  armed_only_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_c) |-> $past(armed_rise_q));

  // R9
  start_held_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_c) |-> $past(start_i));
endmodule

bind frame_align_meas fam_chk #(.FRAME_LEN(FRAME_LEN), .OFF_W(OFF_W)) u_fam_chk (
  .clk(clk), .rst(rst), .fp_i(fp_i), .fmt_gci_i(fmt_gci_i),
  .start_i(start_i), .align_o(align_o)
);

// File: tb/frame_align_meas_tb_top.sv
`timescale 1ns/1ps
module frame_align_meas_tb_top;
  localparam int FL    = 256;
  localparam int OFF_W = 12;
  localparam int SAT   = (1 << OFF_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fp_i, ev_i, fmt_gci_i;
  logic start_i = 1'b0;
  logic [OFF_W:0] align_o;

  int  k = 0;
  int  checks = 0, fails = 0;
  bit  gci = 1'b0, inv = 1'b0, finished = 1'b0;
  int  ev_at = -1, ev2_at = -1, noise_at = -1;
  int  last_off = 0;

  frame_align_meas #(.FRAME_LEN(FL), .OFF_W(OFF_W)) dut_i (
    .clk(clk), .rst(rst), .fp_i(fp_i), .ev_i(ev_i),
    .fmt_gci_i(fmt_gci_i), .start_i(start_i), .align_o(align_o)
  );

  always #4 clk = ~clk;
  always @(posedge clk) k <= k + 1;

  function automatic bit win(int a, int kk);
    return (a >= 0) && (kk >= a) && (kk < a + 3);
  endfunction

  always @(negedge clk) begin
    bit fa, ea;
    fa = (k % FL) < 2;
    ea = win(ev_at, k) | win(ev2_at, k) | win(noise_at, k);
    fmt_gci_i = gci;
    fp_i = gci ? fa : ~fa;
    ev_i = (gci ^ inv) ? ea : ~ea;
  end

  function automatic int exp_off(bit iv, int d);
    if (d < 0 || d >= FL) return SAT;
    return iv ? d + 3 : d;
  endfunction

  task automatic check_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic arm_start(output int ks);
    start_i = 1'b0;
    repeat (FL + 2) @(negedge clk);
    while (k % FL != FL / 2) @(negedge clk);
    start_i = 1'b1;
    ks = k;
  endtask

  task automatic run_meas(bit g, bit iv, int d, int d2, bit noise, string tag);
    int ks, e2, e3, ex;
    gci = g; inv = iv; ev_at = -1; ev2_at = -1; noise_at = -1;
    arm_start(ks);
    e2 = ks + FL / 2 + FL;
    e3 = e2 + FL;
    ev_at    = (d >= 0) ? e2 + d : -1;
    ev2_at   = (d2 >= 0) ? e2 + d2 : -1;
    noise_at = noise ? ks + FL / 2 + 5 : -1;
    ex = exp_off(iv, d);
    while (k != e3) @(negedge clk);
    check_eq({tag, " R7 flag low before close"}, int'(align_o[OFF_W]), 0);
    @(negedge clk);
    check_eq({tag, " R7 flag set"}, int'(align_o[OFF_W]), 1);
    check_eq({tag, " offset"}, int'(align_o[OFF_W-1:0]), ex);
    last_off = ex;
    ev_at = -1; ev2_at = -1; noise_at = -1;
    start_i = 1'b0;
    @(negedge clk);
    check_eq("R8 flag cleared", int'(align_o[OFF_W]), 0);
    check_eq("R8 offset held", int'(align_o[OFF_W-1:0]), last_off);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1 reset word", int'(align_o), 0);

    run_meas(1'b0, 1'b0, 37, -1, 1'b0, "R4 st-bus");
    run_meas(1'b1, 1'b0, 90, -1, 1'b0, "R5 gci");
    run_meas(1'b0, 1'b0, 0, -1, 1'b0, "R4 coincident open");
    run_meas(1'b1, 1'b0, FL, -1, 1'b0, "R6 coincident close");
    run_meas(1'b0, 1'b0, -1, -1, 1'b0, "R6 no edge");
    run_meas(1'b0, 1'b1, 7, -1, 1'b0, "R5 st-bus wrong polarity");
    run_meas(1'b1, 1'b1, 20, -1, 1'b0, "R5 gci wrong polarity");
    run_meas(1'b1, 1'b0, 50, 60, 1'b1, "R3 skip-frame noise, R4 first edge");

    begin : early_start
      start_i = 1'b0;
      repeat (FL / 4) @(negedge clk);
      start_i = 1'b1;
      ev_at = k + 2 * FL + 10;
      repeat (4 * FL) @(negedge clk);
      check_eq("R2 early rise no flag", int'(align_o[OFF_W]), 0);
      check_eq("R2 early rise offset kept", int'(align_o[OFF_W-1:0]), last_off);
      ev_at = -1;
    end

    begin : abandon
      int ks, e2, e3;
      gci = 1'b0; inv = 1'b0;
      arm_start(ks);
      e2 = ks + FL / 2 + FL;
      e3 = e2 + FL;
      ev_at = e2 + 4;
      while (k != e2 + FL / 2) @(negedge clk);
      start_i = 1'b0;
      while (k != e3 + 2) @(negedge clk);
      check_eq("R9 abandoned no flag", int'(align_o[OFF_W]), 0);
      check_eq("R9 abandoned offset kept", int'(align_o[OFF_W-1:0]), last_off);
      ev_at = -1;
    end

    for (int i = 0; i < 8; i++) begin
      bit g;
      int d;
      g = 1'($urandom % 2);
      d = int'($urandom % (FL - 12));
      run_meas(g, 1'b0, d, d + 6, 1'b0, "R4 random");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule